// File: doc/BRIEF.md
# PCI Function Power-State Controller

This block keeps the device power state of a single PCI function. It runs on a clock from the auxiliary supply domain. Configuration writes move the function between its full-power, light-sleep and deep-sleep states. The block watches the bus segment reset line and decides what happens to the function's context when that line changes. It drives a one-cycle clear pulse that the rest of the function uses to discard its working context. It also raises a power-management-event (PME) request when an enabled event is pending.

The reset line is brought into the auxiliary clock domain through a two-flop synchroniser. The block handles it in one of two ways. A function fed only from main power treats a low reset line as a reset that lasts as long as the line stays low. A function fed from the auxiliary supply reads the low-to-high edge of the line as the sign that bus power is back. A line that simply stays low never triggers a reset for such a function. When main power is absent, an aux-powered function stays in the powered-off state. Its PME enable and status survive a reset only if it runs from auxiliary power and can signal events from that powered-off state.

Top module: `pci_pwr_ctrl`

## Requirements
- R1: After the auxiliary-domain reset, `pwr_state` is 0 (D0-uninitialised), `pme_en`, `pme_sts` and `pme_req` are 0, and `ctx_clr` stays low. State codes on `pwr_state`: 0 = D0-uninitialised, 1 = D0-active, 2 = D1, 3 = D2, 4 = D3hot, 5 = D3cold.
- R2: An accepted configuration write whose 2-bit `cfg_pstate` code is supported sets the state as follows. Code 01 gives D1, 10 gives D2 and 11 gives D3hot. Code 00 gives D0-active from D1 or D2. Code 00 from D3hot gives D0-uninitialised, and `pme_en` and `pme_sts` keep their values.
- R3: A write whose `cfg_pstate` code has a 0 in `pstate_sup` leaves the state unchanged. Bit n of `pstate_sup` enables code n.
- R4: From D0-uninitialised, a write of code 00 with `cfg_mem_io_en` set moves the function to D0-active.
- R5: When `aux_supply` is 0, a low synchronised reset forces D0-uninitialised and clears `pme_en` and `pme_sts`. The function stays there for as long as the line is low, and configuration writes are ignored during that time.
- R6: When `aux_supply` is 1, a reset line held low never changes the state. The state changes to D0-uninitialised only on the synchronised low-to-high edge, and only while main power is present.
- R7: When `aux_supply` is 1 and `main_pwr_ok` is 0, the state is D3cold from the next cycle on, and configuration writes are ignored.
- R8: On a reset, `pme_en` and `pme_sts` keep their values if `aux_supply` and `pme_d3cold_cap` are both 1. In every other case they are cleared.
- R9: `ctx_clr` is high for exactly one cycle, the first cycle of each entry into D0-uninitialised, whether the entry comes from a reset or from software.
- R10: `pme_event` sets `pme_sts` only while the current state has a 1 in `pme_mask`. The mask bits are 0 = D0, 1 = D1, 2 = D2, 3 = D3hot, 4 = D3cold. Writing 1 to `cfg_pme_sts_w1c` clears `pme_sts`. `pme_req` is high exactly when `pme_en`, `pme_sts` and the mask bit of the current state are all set, so it drops in the cycle after the clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aux | input | 1 | Auxiliary-domain clock |
| aux_rst_n | input | 1 | Auxiliary-domain power-on reset, active low |
| bus_rst_n | input | 1 | Bus segment reset line, active low, asynchronous |
| main_pwr_ok | input | 1 | Main bus power present |
| aux_supply | input | 1 | Strap: function runs from auxiliary power |
| pme_d3cold_cap | input | 1 | Strap: function can signal PME from D3cold |
| pstate_sup | input | 4 | Supported power-state codes, bit n enables code n |
| pme_mask | input | 5 | States from which PME may be signalled |
| pme_event | input | 1 | Wake event from the function |
| cfg_we | input | 1 | Configuration write strobe for the power-management fields |
| cfg_pstate | input | 2 | Requested power-state code |
| cfg_mem_io_en | input | 1 | Memory or I/O enable carried by the same write |
| cfg_pme_en | input | 1 | New PME enable value |
| cfg_pme_sts_w1c | input | 1 | Write 1 to clear PME status |
| pwr_state | output | 3 | Current power state code |
| ctx_clr | output | 1 | One-cycle pulse: discard functional context |
| pme_en | output | 1 | PME enable field |
| pme_sts | output | 1 | PME status field |
| pme_req | output | 1 | PME request to the bus |

## Verification
The in-RTL properties check these rules on every cycle: the clear pulse lasts one cycle and falls in D0-uninitialised; the synchronised edge is a single pulse; a low line holds a main-powered function in D0-uninitialised; loss of main power leads to D3cold; a low line never moves an aux-powered function; and the PME fields follow the retention rule and the write-one-to-clear rule. The bench scenarios cover what needs a sequence of steps. These are the whole cycle of power loss, restore and reset release for both straps, software moves out of D3hot, and ignored writes with unsupported codes. They also show that events are masked by state and that the clear pulse is counted once per entry.

// File: rtl/pci_pm_pkg.sv
package pci_pm_pkg;

  typedef enum logic [2:0] {
    PS_D0U = 3'd0,
    PS_D0A = 3'd1,
    PS_D1  = 3'd2,
    PS_D2  = 3'd3,
    PS_D3H = 3'd4,
    PS_D3C = 3'd5
  } pstate_e;

  // PME mask slot for a state: D0 variants share slot 0.
  function automatic logic pme_allowed(input logic [4:0] mask, input pstate_e s);
    case (s)
      PS_D0U, PS_D0A: pme_allowed = mask[0];
      PS_D1:          pme_allowed = mask[1];
      PS_D2:          pme_allowed = mask[2];
      PS_D3H:         pme_allowed = mask[3];
      default:        pme_allowed = mask[4];
    endcase
  endfunction

  // Target of a software state write.
  function automatic pstate_e sw_target(input logic [1:0] code, input pstate_e cur,
                                        input logic mem_io);
    case (code)
      2'd1: sw_target = PS_D1;
      2'd2: sw_target = PS_D2;
      2'd3: sw_target = PS_D3H;
      default: begin
        if (cur == PS_D3H)      sw_target = PS_D0U;
        else if (cur == PS_D0U) sw_target = mem_io ? PS_D0A : PS_D0U;
        else                    sw_target = PS_D0A;
      end
    endcase
  endfunction

endpackage

// File: rtl/pci_pm_rst_sync.sv
module pci_pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic bus_rst_n,
  output logic rst_lvl,
  output logic rst_rise
);
  logic [STAGES-1:0] sync_q;
  logic              lvl_d;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
      lvl_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], bus_rst_n};
      lvl_d  <= sync_q[STAGES-1];
    end
  end

  assign rst_lvl  = sync_q[STAGES-1];
  assign rst_rise = rst_lvl & ~lvl_d;

  // R6
  r6_single_edge_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_rise |=> !rst_rise);
endmodule

// File: rtl/pci_pm_fsm.sv
module pci_pm_fsm
  import pci_pm_pkg::*;
#(
  parameter int NUM_CODES = 4,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              aux_supply,
  input  logic              main_pwr_ok,
  input  logic              rst_lvl,
  input  logic              rst_rise,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_pstate,
  input  logic              cfg_mem_io_en,
  input  logic [NUM_CODES-1:0] pstate_sup,
  output pstate_e           state,
  output logic              ctx_clr,
  output logic              wr_ok,
  output logic              rst_evt
);
  pstate_e state_nxt;
  logic    bus_off;

  assign bus_off = aux_supply & ~main_pwr_ok;
  assign rst_evt = aux_supply ? (rst_rise & main_pwr_ok) : ~rst_lvl;
  assign wr_ok   = cfg_we & rst_lvl & ~bus_off & ~rst_evt & (state != PS_D3C);

  always_comb begin
    state_nxt = state;
    if (bus_off)     state_nxt = PS_D3C;
    else if (rst_evt) state_nxt = PS_D0U;
    else if (wr_ok && pstate_sup[cfg_pstate])
      state_nxt = sw_target(cfg_pstate, state, cfg_mem_io_en);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state   <= PS_D0U;
      ctx_clr <= 1'b0;
    end else begin
      state   <= state_nxt;
      ctx_clr <= (state_nxt == PS_D0U) && (state != PS_D0U);
    end
  end

  // R9
  r9_pulse_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ctx_clr |=> !ctx_clr);
  // R9
  r9_pulse_state_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ctx_clr |-> state == PS_D0U);
  // R5
  r5_level_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!aux_supply && !rst_lvl) |=> state == PS_D0U);
  // R6
  r6_low_ignored_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (aux_supply && main_pwr_ok && !rst_lvl) |=> state == $past(state));
  // R7
  r7_power_loss_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (aux_supply && !main_pwr_ok) |=> state == PS_D3C);
endmodule

// File: rtl/pci_pm_pme.sv
module pci_pm_pme
  import pci_pm_pkg::*;
#(
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              arst_n,
  input  pstate_e           state,
  input  logic [MASK_W-1:0] pme_mask,
  input  logic              pme_event,
  input  logic              wr_ok,
  input  logic              cfg_pme_en,
  input  logic              cfg_pme_sts_w1c,
  input  logic              rst_evt,
  input  logic              keep_ctx,
  output logic              pme_en,
  output logic              pme_sts,
  output logic              pme_req
);
  logic state_ok, evt_hit, ctx_wipe;

  assign state_ok = pme_allowed(pme_mask, state);
  assign evt_hit  = pme_event & state_ok;
  assign ctx_wipe = rst_evt & ~keep_ctx;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pme_en  <= 1'b0;
      pme_sts <= 1'b0;
    end else if (ctx_wipe) begin
      pme_en  <= 1'b0;
      pme_sts <= 1'b0;
    end else begin
      if (wr_ok) pme_en <= cfg_pme_en;
      if (evt_hit)                      pme_sts <= 1'b1;
      else if (wr_ok && cfg_pme_sts_w1c) pme_sts <= 1'b0;
    end
  end

  assign pme_req = pme_en & pme_sts & state_ok;

  // R8
  r8_keep_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_evt && keep_ctx) |=> (pme_en == $past(pme_en)) && (pme_sts || !$past(pme_sts)));
  // R8
  r8_wipe_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_evt && !keep_ctx) |=> !pme_en && !pme_sts);
  // R10
  r10_w1c_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_ok && cfg_pme_sts_w1c && !pme_event && !rst_evt) |=> !pme_sts);
endmodule

// File: rtl/pci_pwr_ctrl.sv
module pci_pwr_ctrl
  import pci_pm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CODES   = 4,
  parameter int MASK_W      = 5,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                 clk_aux,
  input  logic                 aux_rst_n,
  input  logic                 bus_rst_n,
  input  logic                 main_pwr_ok,
  input  logic                 aux_supply,
  input  logic                 pme_d3cold_cap,
  input  logic [NUM_CODES-1:0] pstate_sup,
  input  logic [MASK_W-1:0]    pme_mask,
  input  logic                 pme_event,
  input  logic                 cfg_we,
  input  logic [CODE_W-1:0]    cfg_pstate,
  input  logic                 cfg_mem_io_en,
  input  logic                 cfg_pme_en,
  input  logic                 cfg_pme_sts_w1c,
  output logic [2:0]           pwr_state,
  output logic                 ctx_clr,
  output logic                 pme_en,
  output logic                 pme_sts,
  output logic                 pme_req
);
  logic    rst_lvl, rst_rise, wr_ok, rst_evt, keep_ctx;
  pstate_e state;

  assign keep_ctx  = aux_supply & pme_d3cold_cap;
  assign pwr_state = state;

  pci_pm_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_aux), .arst_n(aux_rst_n), .bus_rst_n(bus_rst_n),
    .rst_lvl(rst_lvl), .rst_rise(rst_rise));

  pci_pm_fsm #(.NUM_CODES(NUM_CODES)) u_fsm (
    .clk(clk_aux), .arst_n(aux_rst_n), .aux_supply(aux_supply),
    .main_pwr_ok(main_pwr_ok), .rst_lvl(rst_lvl), .rst_rise(rst_rise),
    .cfg_we(cfg_we), .cfg_pstate(cfg_pstate), .cfg_mem_io_en(cfg_mem_io_en),
    .pstate_sup(pstate_sup), .state(state), .ctx_clr(ctx_clr),
    .wr_ok(wr_ok), .rst_evt(rst_evt));

  pci_pm_pme #(.MASK_W(MASK_W)) u_pme (
    .clk(clk_aux), .arst_n(aux_rst_n), .state(state), .pme_mask(pme_mask),
    .pme_event(pme_event), .wr_ok(wr_ok), .cfg_pme_en(cfg_pme_en),
    .cfg_pme_sts_w1c(cfg_pme_sts_w1c), .rst_evt(rst_evt), .keep_ctx(keep_ctx),
    .pme_en(pme_en), .pme_sts(pme_sts), .pme_req(pme_req));
endmodule

// File: tb/pci_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module pci_pwr_ctrl_bench;
  localparam logic [2:0] S_D0U = 3'd0, S_D0A = 3'd1, S_D1 = 3'd2, S_D2 = 3'd3,
                         S_D3H = 3'd4, S_D3C = 3'd5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic aux_rst_n = 1'b0, bus_rst_n = 1'b0, main_pwr_ok = 1'b1;
  logic aux_supply = 1'b0, pme_d3cold_cap = 1'b0;
  logic [3:0] pstate_sup = 4'b1111;
  logic [4:0] pme_mask = 5'b11111;
  logic pme_event = 1'b0, cfg_we = 1'b0, cfg_mem_io_en = 1'b0;
  logic cfg_pme_en = 1'b0, cfg_pme_sts_w1c = 1'b0;
  logic [1:0] cfg_pstate = 2'd0;
  logic [2:0] pwr_state;
  logic ctx_clr, pme_en, pme_sts, pme_req;

  pci_pwr_ctrl u_pci_pwr_ctrl (
    .clk_aux(clk), .aux_rst_n(aux_rst_n), .bus_rst_n(bus_rst_n),
    .main_pwr_ok(main_pwr_ok), .aux_supply(aux_supply),
    .pme_d3cold_cap(pme_d3cold_cap), .pstate_sup(pstate_sup),
    .pme_mask(pme_mask), .pme_event(pme_event), .cfg_we(cfg_we),
    .cfg_pstate(cfg_pstate), .cfg_mem_io_en(cfg_mem_io_en),
    .cfg_pme_en(cfg_pme_en), .cfg_pme_sts_w1c(cfg_pme_sts_w1c),
    .pwr_state(pwr_state), .ctx_clr(ctx_clr), .pme_en(pme_en),
    .pme_sts(pme_sts), .pme_req(pme_req));

  typedef struct {
    logic [2:0] st;
    logic       en, sts, req;
    int         pulses;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0, n_fail = 0, pulse_cnt = 0;
  bit   done = 1'b0;

  // Monitor: counts clear pulses and compares each queued expectation.
  always @(negedge clk) begin
    if (aux_rst_n && ctx_clr) pulse_cnt++;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (pwr_state !== e.st || pme_en !== e.en || pme_sts !== e.sts ||
          pme_req !== e.req || pulse_cnt != e.pulses) begin
        n_fail++;
        $display("FAIL %s: got st=%0d en=%b sts=%b req=%b pulses=%0d, exp st=%0d en=%b sts=%b req=%b pulses=%0d",
                 e.tag, pwr_state, pme_en, pme_sts, pme_req, pulse_cnt,
                 e.st, e.en, e.sts, e.req, e.pulses);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [2:0] st, input logic en, input logic sts,
                            input logic req, input int pulses, input string tag);
    exp_t e;
    #1;
    e.st = st; e.en = en; e.sts = sts; e.req = req; e.pulses = pulses; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [1:0] code, input logic mem, input logic en,
                           input logic w1c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pstate = code; cfg_mem_io_en = mem;
    cfg_pme_en = en; cfg_pme_sts_w1c = w1c;
    @(negedge clk);
    cfg_we = 1'b0; cfg_pme_sts_w1c = 1'b0;
  endtask

  task automatic fire_event();
    @(negedge clk);
    pme_event = 1'b1;
    @(negedge clk);
    pme_event = 1'b0;
  endtask

  task automatic aux_reset(input logic aux, input logic cap);
    @(negedge clk);
    aux_rst_n = 1'b0;
    aux_supply = aux; pme_d3cold_cap = cap;
    bus_rst_n = 1'b1; main_pwr_ok = 1'b1;
    pstate_sup = 4'b1111; pme_mask = 5'b11111;
    tick(2);
    aux_rst_n = 1'b1;
    tick(5);
  endtask

  initial begin
    // Phase A: main-powered function, level-sensitive reset
    tick(3);
    aux_rst_n = 1'b1;
    tick(4);
    expect_out(S_D0U, 0, 0, 0, 0, "R1 reset state");
    bus_rst_n = 1'b1; tick(4);
    expect_out(S_D0U, 0, 0, 0, 0, "R5 release keeps D0U");
    cfg_write(2'd0, 1, 0, 0);
    expect_out(S_D0A, 0, 0, 0, 0, "R4 mem/io enable");
    cfg_write(2'd0, 1, 1, 0);
    fire_event();
    expect_out(S_D0A, 1, 1, 1, 0, "R10 event sets status");
    cfg_write(2'd0, 1, 1, 1);
    expect_out(S_D0A, 1, 0, 0, 0, "R10 write-one-to-clear");
    cfg_write(2'd2, 1, 1, 0);
    expect_out(S_D2, 1, 0, 0, 0, "R2 to D2");
    cfg_write(2'd0, 1, 1, 0);
    expect_out(S_D0A, 1, 0, 0, 0, "R2 D2 to D0A");
    cfg_write(2'd3, 1, 1, 0);
    fire_event();
    expect_out(S_D3H, 1, 1, 1, 0, "R2 to D3hot");
    cfg_write(2'd0, 0, 1, 0);
    expect_out(S_D0U, 1, 1, 1, 1, "R2 R9 D3hot to D0U keeps PME");
    cfg_write(2'd0, 1, 1, 0);
    expect_out(S_D0A, 1, 1, 1, 1, "R4 second enable");
    bus_rst_n = 1'b0; tick(6);
    expect_out(S_D0U, 0, 0, 0, 2, "R5 R8 level reset clears");
    tick(10);
    expect_out(S_D0U, 0, 0, 0, 2, "R9 one pulse while held");
    cfg_write(2'd3, 1, 1, 0);
    expect_out(S_D0U, 0, 0, 0, 2, "R5 write ignored in reset");
    bus_rst_n = 1'b1; tick(4);
    cfg_write(2'd0, 1, 0, 0);
    pstate_sup = 4'b1001;
    cfg_write(2'd1, 1, 0, 0);
    expect_out(S_D0A, 0, 0, 0, 2, "R3 unsupported code");
    pstate_sup = 4'b1111; pme_mask = 5'b11101;
    cfg_write(2'd1, 1, 1, 0);
    fire_event();
    expect_out(S_D1, 1, 0, 0, 2, "R10 masked event");
    cfg_write(2'd0, 1, 1, 0);
    fire_event();
    expect_out(S_D0A, 1, 1, 1, 2, "R10 unmasked event");
    cfg_write(2'd1, 1, 1, 0);
    expect_out(S_D1, 1, 1, 0, 2, "R10 request gated by mask");

    // Phase B: aux-powered, D3cold-capable
    aux_reset(1'b1, 1'b1);
    expect_out(S_D0U, 0, 0, 0, 2, "R1 aux reset state");
    cfg_write(2'd0, 1, 1, 0);
    cfg_write(2'd3, 1, 1, 0);
    fire_event();
    expect_out(S_D3H, 1, 1, 1, 2, "R2 aux D3hot");
    bus_rst_n = 1'b0; tick(6);
    expect_out(S_D3H, 1, 1, 1, 2, "R6 low line ignored");
    main_pwr_ok = 1'b0; tick(2);
    expect_out(S_D3C, 1, 1, 1, 2, "R7 power loss");
    cfg_write(2'd0, 1, 0, 1);
    expect_out(S_D3C, 1, 1, 1, 2, "R7 write ignored in D3cold");
    main_pwr_ok = 1'b1; tick(5);
    expect_out(S_D3C, 1, 1, 1, 2, "R6 power back, line low");
    bus_rst_n = 1'b1; tick(5);
    expect_out(S_D0U, 1, 1, 1, 3, "R6 R8 rising edge keeps PME");
    cfg_write(2'd0, 1, 1, 0);
    bus_rst_n = 1'b0; tick(5);
    expect_out(S_D0A, 1, 1, 1, 3, "R6 low pulse in D0A");
    bus_rst_n = 1'b1; tick(5);
    expect_out(S_D0U, 1, 1, 1, 4, "R8 R9 edge reset from D0A");

    // Phase C: aux-powered, not D3cold-capable
    aux_reset(1'b1, 1'b0);
    expect_out(S_D0U, 0, 0, 0, 4, "R1 aux reset no cap");
    cfg_write(2'd0, 1, 1, 0);
    fire_event();
    expect_out(S_D0A, 1, 1, 1, 4, "R10 event no cap");
    bus_rst_n = 1'b0; tick(5);
    bus_rst_n = 1'b1; tick(5);
    expect_out(S_D0U, 0, 0, 0, 5, "R8 context cleared without cap");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule